// File: doc/BRIEF.md
# Recovered-Clock Frequency Lock Monitor

This block decides whether a clock recovery loop has locked onto incoming serial data. It does this by comparing the loop's recovered clock with a local reference clock. A free-running counter in the recovered-clock domain is sampled once per measurement window. The window is a fixed number of reference cycles. The number of recovered cycles seen in that window crosses into the reference domain through a toggle handshake. There it is compared against an expected count, which is derived from the selected line rate and from whether a high or a low reference is fitted.

Two consecutive windows inside the tolerance band declare lock. A single window outside the band drops it. While unlocked, the `use_ref` output steers the loop onto the local reference so that the recovered clock keeps a sane frequency. Measurement continues in every window, so lock is regained without outside help once the data path is healthy again. A shutdown input forces the unlocked state for as long as it is held.

Top module: `freq_lock_monitor`

## Requirements
- R1: While `rst_n` is low and after its release, `locked` is 0 and `use_ref` is 1 until lock is declared.
- R2: The expected count per window is 2^(WIN_LOG2 + k + 3·`ref_lo`), where k follows `rate_sel`:
  - codes 0 and 1 give k=4 (2488.32 Mb/s and 2125 Mb/s);
  - codes 2, 3 and 4 give k=3 (1244.16, 1250 and 1062.5 Mb/s);
  - code 5 gives k=2 (622.08 Mb/s);
  - codes 6 and 7 give k=0 (155.52 Mb/s).
  A clock whose ratio to the reference matches the selected setting is accepted; one that does not match is rejected.
- R3: A window is in tolerance when |count − expected| ≤ expected >> `tol_shift`. Both too fast and too slow count as out of tolerance.
- R4: `locked` rises only on the second of two consecutive in-tolerance window results, never on the first.
- R5: A single out-of-tolerance window result clears `locked` on the next reference edge.
- R6: `use_ref` is always the inverse of `locked`, so the loop tracks the reference whenever it is unlocked.
- R7: While `shutdown` is high, `locked` is 0 from the next reference edge, and window results are discarded. After release, two fresh in-tolerance windows are required before lock is declared.
- R8: Windows keep running while unlocked. A recovered clock that returns to tolerance regains lock without a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Local reference clock; window timing and lock state |
| rec_clk | input | 1 | Recovered clock from the loop |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| rate_sel | input | 3 | Line-rate code (see R2) |
| ref_lo | input | 1 | 1 = low reference, which is one eighth of the high reference |
| tol_shift | input | 4 | Tolerance as a right shift of the expected count |
| shutdown | input | 1 | Forces loss of lock |
| locked | output | 1 | Lock-detect flag |
| use_ref | output | 1 | 1 = loop follows the reference, 0 = loop follows data |

## Verification
A window result can arrive in the same reference cycle in which `shutdown` is high. In that case the shutdown must win, and the result must not count toward the two-window rule. The bench provokes this by holding `shutdown` across several windows of a perfectly matched clock, so results certainly land during the shutdown. It then judges the outcome at the ports: `locked` stays low throughout. After release, `locked` is still low when fewer than two windows can have completed, and it rises only once two fresh windows have passed.

// File: rtl/freq_lock_monitor.sv
module freq_lock_monitor #(
  parameter int WIN_LOG2 = 10,
  parameter int TW       = 4
) (
  input  logic          ref_clk,
  input  logic          rec_clk,
  input  logic          rst_n,
  input  logic [2:0]    rate_sel,
  input  logic          ref_lo,
  input  logic [TW-1:0] tol_shift,
  input  logic          shutdown,
  output logic          locked,
  output logic          use_ref
);
  localparam int CW = WIN_LOG2 + 9;

  // reference domain: window timer and request toggle
  logic [WIN_LOG2-1:0] win_cnt;
  logic                req_tg;
  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      win_cnt <= '0;
      req_tg  <= 1'b0;
    end else begin
      win_cnt <= win_cnt + 1'b1;
      if (&win_cnt) req_tg <= ~req_tg;
    end

  // recovered domain: free-running count, snapshot on request
  logic [2:0]    req_s;
  logic [CW-1:0] rcnt, rlast, hold;
  logic          ack_tg;
  always_ff @(posedge rec_clk or negedge rst_n)
    if (!rst_n) begin
      req_s  <= '0;
      rcnt   <= '0;
      rlast  <= '0;
      hold   <= '0;
      ack_tg <= 1'b0;
    end else begin
      req_s <= {req_s[1:0], req_tg};
      rcnt  <= rcnt + 1'b1;
      if (req_s[2] ^ req_s[1]) begin
        hold   <= rcnt - rlast;
        rlast  <= rcnt;
        ack_tg <= ~ack_tg;
      end
    end

  // back in reference domain
  logic [2:0] ack_s;
  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) ack_s <= '0;
    else        ack_s <= {ack_s[1:0], ack_tg};
  wire res_valid = ack_s[2] ^ ack_s[1];

  logic [3:0] k;
  always_comb
    case (rate_sel)
      3'd0, 3'd1:       k = 4'd4;
      3'd2, 3'd3, 3'd4: k = 4'd3;
      3'd5:             k = 4'd2;
      default:          k = 4'd0;
    endcase

  wire [7:0]    shamt    = 8'(WIN_LOG2) + {4'd0, k} + (ref_lo ? 8'd3 : 8'd0);
  wire [CW-1:0] expected = {{(CW-1){1'b0}}, 1'b1} << shamt;
  wire [CW-1:0] margin   = expected >> tol_shift;
  wire [CW-1:0] diff     = (hold >= expected) ? hold - expected : expected - hold;
  wire          in_tol   = diff <= margin;

  logic good;
  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      locked <= 1'b0;
      good   <= 1'b0;
    end else if (shutdown) begin
      locked <= 1'b0;
      good   <= 1'b0;
    end else if (res_valid) begin
      if (in_tol) begin
        locked <= good;
        good   <= 1'b1;
      end else begin
        locked <= 1'b0;
        good   <= 1'b0;
      end
    end

  assign use_ref = ~locked;

  p_shutdown_unlocks_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    shutdown |=> !locked);
  p_lock_needs_two_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(locked) |-> $past(good && res_valid && in_tol));
  p_bad_window_drops_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (res_valid && !in_tol) |=> !locked);
  p_hold_between_results_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!res_valid && !shutdown) |=> $stable(locked));
  p_steer_follows_lock_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    use_ref != locked);
endmodule

// File: tb/freq_lock_monitor_tb_top.sv
`timescale 1ns/1ps
module freq_lock_monitor_tb_top;
  logic ref_clk = 1'b0, rec_clk = 1'b0, rst_n = 1'b0;
  logic [2:0] rate_sel = 3'd0;
  logic ref_lo = 1'b0, shutdown = 1'b0;
  logic [3:0] tol_shift = 4'd3;
  logic locked, use_ref;
  realtime rec_half = 0.625;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  freq_lock_monitor #(.WIN_LOG2(6), .TW(4)) dut_i (
    .ref_clk(ref_clk), .rec_clk(rec_clk), .rst_n(rst_n), .rate_sel(rate_sel),
    .ref_lo(ref_lo), .tol_shift(tol_shift), .shutdown(shutdown),
    .locked(locked), .use_ref(use_ref));

  always #10 ref_clk = ~ref_clk;
  initial forever #(rec_half) rec_clk = ~rec_clk;

  typedef struct packed {
    logic [2:0] rate; logic lo; logic [7:0] ratio; logic [7:0] pct; logic exp;
  } vec_t;
  localparam vec_t VEC [11] = '{
    '{3'd0, 1'b0, 8'd16,  8'd100, 1'b1},  // R2 2488 Mb/s, high ref
    '{3'd6, 1'b0, 8'd1,   8'd100, 1'b1},  // R2 155 Mb/s
    '{3'd5, 1'b1, 8'd32,  8'd100, 1'b1},  // R2 622 Mb/s, low ref
    '{3'd2, 1'b0, 8'd8,   8'd106, 1'b1},  // R3 inside band
    '{3'd3, 1'b0, 8'd8,   8'd125, 1'b0},  // R3 too fast
    '{3'd4, 1'b0, 8'd8,   8'd75,  1'b0},  // R3 too slow
    '{3'd0, 1'b1, 8'd128, 8'd100, 1'b1},  // R2 highest ratio
    '{3'd6, 1'b1, 8'd8,   8'd100, 1'b1},  // R2 low ref, lowest rate
    '{3'd7, 1'b0, 8'd1,   8'd100, 1'b1},  // R2 code 7 acts as code 6
    '{3'd0, 1'b0, 8'd8,   8'd100, 1'b0},  // R2 ratio mismatch
    '{3'd5, 1'b0, 8'd16,  8'd100, 1'b0}   // R2 ratio mismatch
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic set_clk(input int ratio, input int pct);
    rec_half = 1000.0 / (ratio * pct);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(4);
    chk(locked == 1'b0 && use_ref == 1'b1, "R1", {locked, use_ref}, 2'b01);
    rst_n = 1'b1;
  endtask

  initial begin
    cyc(2);
    foreach (VEC[i]) begin
      rate_sel = VEC[i].rate;
      ref_lo   = VEC[i].lo;
      set_clk(VEC[i].ratio, VEC[i].pct);
      do_reset();
      cyc(100);
      chk(locked == 1'b0, "R4 first window only", locked, 0);
      cyc(110);
      chk(locked == VEC[i].exp, VEC[i].pct == 8'd100 ? "R2" : "R3", locked, VEC[i].exp);
      chk(use_ref == ~locked, "R6", use_ref, ~locked);
    end

    // R7: shutdown overrides matched frequency and discards results
    rate_sel = 3'd0; ref_lo = 1'b0; set_clk(16, 100);
    do_reset();
    cyc(210);
    chk(locked == 1'b1, "R8 lock before shutdown", locked, 1);
    shutdown = 1'b1;
    cyc(1);
    chk(locked == 1'b0, "R7 immediate", locked, 0);
    for (int j = 0; j < 6; j++) begin
      cyc(32);
      chk(locked == 1'b0 && use_ref == 1'b1, "R7 held", locked, 0);
    end
    shutdown = 1'b0;
    cyc(40);
    chk(locked == 1'b0, "R7 two fresh windows", locked, 0);
    cyc(160);
    chk(locked == 1'b1, "R7 relock", locked, 1);

    // R5: loss of lock on a fast clock, then R8 recovery without reset
    set_clk(16, 125);
    cyc(140);
    chk(locked == 1'b0, "R5", locked, 0);
    chk(use_ref == 1'b1, "R6 unlocked steers to ref", use_ref, 1);
    set_clk(16, 100);
    cyc(220);
    chk(locked == 1'b1, "R8", locked, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule